// File: doc/BRIEF.md
# Context-Tagged Indirect Branch Target Buffer

This block is a small direct-mapped buffer of predicted targets for indirect branches, shared by two hardware threads of one core. Each entry is trained from a resolved branch and remembers more than the target. It also records whether the core was in kernel mode when it was written, and which hardware thread wrote it. A lookup yields a predicted target only when the entry is valid, its partial tag matches the branch address, and the enabled context checks agree with the requester. With these checks, predictor state trained in user mode cannot steer a kernel-mode prediction, and one thread cannot plant predictions for its sibling.

Software can also sanitize the buffer. A barrier command invalidates every entry at once. An optional policy bit turns each context-transition event (for example, entry to the kernel on a system call) into the same invalidation. A small policy register enables or disables each isolation feature. Build parameters choose, for each feature, whether it comes up off, comes up on, or is forced on so that software cannot turn it off.

Top module: `ctx_btb`

## Requirements
- R1: After reset no lookup hits, and the policy output `cfgPolicy` reads 3'b011: bit 0 is mode isolation (on), bit 1 is thread isolation (on), and bit 2 is flush on context event (off).
- R2: An update with `upValid` high writes the entry at index PC[5:2] at the next rising edge. The entry stores valid, the tag PC[31:6], the target, the update's mode bit and the update's thread id. After that edge, a lookup of the same PC from the same context hits with that target. `lkTarget` reads zero whenever `lkHit` is low.
- R3: A lookup whose PC[31:6] differs from the stored tag at its index misses. A later update to the same index overwrites the older entry.
- R4: While policy bit 0 is set, a hit requires the stored mode bit (1 = kernel) to equal `lkKernel`. While the bit is clear, the mode is ignored.
- R5: While policy bit 1 is set, a hit requires the stored thread id to equal `lkThread`. While the bit is clear, entries are shared between threads.
- R6: `flushReq` clears every valid bit at the next edge. A lookup in the same cycle as the flush misses, and an update in that cycle is dropped.
- R7: While policy bit 2 is set, a `ctxEvt` pulse acts exactly like `flushReq`. While the bit is clear, `ctxEvt` has no effect.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the entry's contents from before the update.
- R9: A `cfgWe` cycle loads `cfgWdata` into the policy bits at the next edge. The exception is a feature built as forced on: its bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkThread | input | 1 | Hardware thread of the lookup |
| lkKernel | input | 1 | Requester is in kernel mode |
| lkPc | input | 32 | Address of the branch being predicted |
| lkHit | output | 1 | Prediction is valid |
| lkTarget | output | 32 | Predicted target (zero on miss) |
| upValid | input | 1 | Train with a resolved branch |
| upThread | input | 1 | Thread that resolved the branch |
| upKernel | input | 1 | Mode in which the branch resolved |
| upPc | input | 32 | Address of the resolved branch |
| upTarget | input | 32 | Resolved target |
| flushReq | input | 1 | Barrier: invalidate all entries |
| ctxEvt | input | 1 | Context-transition event |
| cfgWe | input | 1 | Write the policy register |
| cfgWdata | input | 3 | New policy bits |
| cfgPolicy | output | 3 | Current policy bits |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- a flush or an enabled context event leaves no valid entry behind and never coincides with a hit;
- every hit agrees with the stored mode and thread whenever those checks are enabled;
- a trained entry is valid afterwards;
- a writable policy bit takes the written value.

Other behaviour appears only in the bench's scenarios:
- the actual target values and tag aliasing between addresses sharing an index;
- overwriting on retraining;
- the old-contents result of a lookup that collides with an update;
- a context event that is ignored while its policy bit is clear;
- a policy bit built as forced on that holds against software writes.

// File: rtl/ctxbtb_pkg.sv
package ctxbtb_pkg;
  // per-feature power-up policy
  localparam logic [1:0] POL_OFF    = 2'd0;
  localparam logic [1:0] POL_ON     = 2'd1;
  localparam logic [1:0] POL_FORCED = 2'd2;

  localparam int CFG_W        = 3;
  localparam int CFG_MODE     = 0;
  localparam int CFG_THREAD   = 1;
  localparam int CFG_AUTOFLSH = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic flushAll;
    logic wrEn;
    logic matchMode;
    logic matchThread;
  } strobe_t;
endpackage

// File: rtl/ctxbtb_ctrl.sv
module ctxbtb_ctrl
  import ctxbtb_pkg::*;
#(
  parameter logic [1:0] MODE_POL   = POL_ON,
  parameter logic [1:0] THREAD_POL = POL_ON,
  parameter logic [1:0] FLUSH_POL  = POL_OFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             flushReq,
  input  logic             ctxEvt,
  input  logic             upValid,
  output logic [CFG_W-1:0] cfgQ,
  output strobe_t          strb
);
  localparam logic [1:0] FEAT_POL [CFG_W] = '{MODE_POL, THREAD_POL, FLUSH_POL};

  for (genvar i = 0; i < CFG_W; i++) begin : g_feat
    if (FEAT_POL[i] == POL_FORCED) begin : g_forced
      assign cfgQ[i] = 1'b1;
    end else begin : g_soft
      logic bitQ;
      always_ff @(posedge clk) begin
        if (!rstN)      bitQ <= (FEAT_POL[i] == POL_ON);
        else if (cfgWe) bitQ <= cfgWdata[i];
      end
      assign cfgQ[i] = bitQ;

      // R9: a writable policy bit follows the written value
      p_cfg_write_r9: assert property (@(posedge clk) disable iff (!rstN)
        cfgWe |=> (cfgQ[i] == $past(cfgWdata[i])));
    end
  end

  always_comb begin
    strb.flushAll    = flushReq | (ctxEvt & cfgQ[CFG_AUTOFLSH]);
    strb.wrEn        = upValid & ~strb.flushAll;
    strb.matchMode   = cfgQ[CFG_MODE];
    strb.matchThread = cfgQ[CFG_THREAD];
  end
endmodule

// File: rtl/ctxbtb_array.sv
module ctxbtb_array
  import ctxbtb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int TGT_W   = 32,
  parameter int THREADS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [$clog2(THREADS)-1:0] lkThread,
  input  logic                       lkKernel,
  input  logic [PC_W-1:0]            lkPc,
  output logic                       lkHit,
  output logic [TGT_W-1:0]           lkTarget,
  input  logic [$clog2(THREADS)-1:0] upThread,
  input  logic                       upKernel,
  input  logic [PC_W-1:0]            upPc,
  input  logic [TGT_W-1:0]           upTarget
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int THR_W = $clog2(THREADS);
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_W = PC_W - TAG_LO;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ [ENTRIES];
  logic [TGT_W-1:0]   tgtQ [ENTRIES];
  logic               krnQ [ENTRIES];
  logic [THR_W-1:0]   thrQ [ENTRIES];

  logic [IDX_W-1:0] upIdx, lkIdx;
  logic [TAG_W-1:0] upTag, lkTag;
  assign upIdx = upPc[TAG_LO-1:IDX_LO];
  assign upTag = upPc[PC_W-1:TAG_LO];
  assign lkIdx = lkPc[TAG_LO-1:IDX_LO];
  assign lkTag = lkPc[PC_W-1:TAG_LO];

  always_ff @(posedge clk) begin
    if (!rstN)              validQ <= '0;
    else if (strb.flushAll) validQ <= '0;
    else if (strb.wrEn)     validQ[upIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      tagQ[upIdx] <= upTag;
      tgtQ[upIdx] <= upTarget;
      krnQ[upIdx] <= upKernel;
      thrQ[upIdx] <= upThread;
    end
  end

  logic tagOk, modeOk, thrOk;
  always_comb begin
    tagOk    = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
    modeOk   = !strb.matchMode   || (krnQ[lkIdx] == lkKernel);
    thrOk    = !strb.matchThread || (thrQ[lkIdx] == lkThread);
    lkHit    = tagOk && modeOk && thrOk && !strb.flushAll;
    lkTarget = lkHit ? tgtQ[lkIdx] : '0;
  end

  // R6: after a flush nothing is valid
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (validQ == '0));
  // R6: no hit while a flush is in progress
  p_flush_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |-> !lkHit);
  // R4: a hit agrees with the trained mode
  p_mode_iso_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && strb.matchMode) |-> (krnQ[lkIdx] == lkKernel));
  // R5: a hit agrees with the training thread
  p_thread_iso_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && strb.matchThread) |-> (thrQ[lkIdx] == lkThread));
  // R2: a trained entry is valid afterwards
  p_train_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> validQ[$past(upIdx)]);
endmodule

// File: rtl/ctx_btb.sv
module ctx_btb
  import ctxbtb_pkg::*;
#(
  parameter int         ENTRIES    = 16,
  parameter logic [1:0] MODE_POL   = POL_ON,
  parameter logic [1:0] THREAD_POL = POL_ON,
  parameter logic [1:0] FLUSH_POL  = POL_OFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lkThread,
  input  logic        lkKernel,
  input  logic [31:0] lkPc,
  output logic        lkHit,
  output logic [31:0] lkTarget,
  input  logic        upValid,
  input  logic        upThread,
  input  logic        upKernel,
  input  logic [31:0] upPc,
  input  logic [31:0] upTarget,
  input  logic        flushReq,
  input  logic        ctxEvt,
  input  logic        cfgWe,
  input  logic [2:0]  cfgWdata,
  output logic [2:0]  cfgPolicy
);
  strobe_t strb;

  ctxbtb_ctrl #(
    .MODE_POL(MODE_POL), .THREAD_POL(THREAD_POL), .FLUSH_POL(FLUSH_POL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .flushReq(flushReq), .ctxEvt(ctxEvt), .upValid(upValid),
    .cfgQ(cfgPolicy), .strb(strb)
  );

  ctxbtb_array #(
    .ENTRIES(ENTRIES), .PC_W(32), .TGT_W(32), .THREADS(2)
  ) uArray (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lkThread(lkThread), .lkKernel(lkKernel), .lkPc(lkPc),
    .lkHit(lkHit), .lkTarget(lkTarget),
    .upThread(upThread), .upKernel(upKernel), .upPc(upPc),
    .upTarget(upTarget)
  );

  // R7: an enabled context event gives a miss in its own cycle
  p_ctx_evt_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctxEvt && cfgPolicy[2]) |-> !lkHit);
  // R2: target is zero on a miss
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkTarget == 32'd0));
endmodule

// File: tb/ctx_btb_test.sv
module ctx_btb_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkThread = 0, lkKernel = 0, upValid = 0, upThread = 0, upKernel = 0;
  logic flushReq = 0, ctxEvt = 0, cfgWe = 0;
  logic [31:0] lkPc = '0, upPc = '0, upTarget = '0;
  logic [2:0] cfgWdata = '0;
  logic lkHit, lkHitL;
  logic [31:0] lkTarget, lkTargetL;
  logic [2:0] cfgPolicy, cfgPolicyL;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctx_btb uut (
    .clk(clk), .rstN(rstN), .lkThread(lkThread), .lkKernel(lkKernel),
    .lkPc(lkPc), .lkHit(lkHit), .lkTarget(lkTarget), .upValid(upValid),
    .upThread(upThread), .upKernel(upKernel), .upPc(upPc),
    .upTarget(upTarget), .flushReq(flushReq), .ctxEvt(ctxEvt),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgPolicy(cfgPolicy)
  );

  // variant with mode isolation forced on
  ctx_btb #(.MODE_POL(2'd2)) uutLock (
    .clk(clk), .rstN(rstN), .lkThread(lkThread), .lkKernel(lkKernel),
    .lkPc(lkPc), .lkHit(lkHitL), .lkTarget(lkTargetL), .upValid(upValid),
    .upThread(upThread), .upKernel(upKernel), .upPc(upPc),
    .upTarget(upTarget), .flushReq(flushReq), .ctxEvt(ctxEvt),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgPolicy(cfgPolicyL)
  );

  typedef struct packed {
    logic        isUpd;
    logic        thr;
    logic        krn;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic        hit;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] PA = 32'h0000_1004; // index 1
  localparam logic [31:0] PB = 32'h0000_2004; // index 1, other tag
  localparam logic [31:0] PC = 32'h0000_3038; // index 14
  localparam logic [31:0] T1 = 32'hAAAA_0100;
  localparam logic [31:0] T2 = 32'hBBBB_0200;
  localparam logic [31:0] T3 = 32'hCCCC_0300;

  localparam vec_t VEC [11] = '{
    '{1'b1, 1'b0, 1'b0, PA, T1, 1'b0, 8'd2},
    '{1'b0, 1'b0, 1'b0, PA, T1, 1'b1, 8'd2},   // R2 same context hits
    '{1'b0, 1'b0, 1'b1, PA, 32'd0, 1'b0, 8'd4}, // R4 kernel vs user entry
    '{1'b0, 1'b1, 1'b0, PA, 32'd0, 1'b0, 8'd5}, // R5 sibling thread
    '{1'b0, 1'b0, 1'b0, PB, 32'd0, 1'b0, 8'd3}, // R3 alias tag
    '{1'b1, 1'b1, 1'b1, PC, T2, 1'b0, 8'd2},
    '{1'b0, 1'b1, 1'b1, PC, T2, 1'b1, 8'd2},   // R2 kernel/thread1 entry
    '{1'b0, 1'b0, 1'b1, PC, 32'd0, 1'b0, 8'd5}, // R5
    '{1'b1, 1'b0, 1'b0, PB, T3, 1'b0, 8'd3},
    '{1'b0, 1'b0, 1'b0, PA, 32'd0, 1'b0, 8'd3}, // R3 overwritten
    '{1'b0, 1'b0, 1'b0, PB, T3, 1'b1, 8'd3}
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp,
                       input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive a lookup now and compare outputs 1 ns later
  task automatic look(input logic thr, input logic krn, input logic [31:0] pc,
                      input logic expHit, input logic [31:0] expTgt,
                      input string req);
    lkThread = thr; lkKernel = krn; lkPc = pc;
    #1;
    check({31'd0, lkHit, lkTarget}, {31'd0, expHit, expTgt}, req);
  endtask

  task automatic train(input logic thr, input logic krn, input logic [31:0] pc,
                       input logic [31:0] tgt);
    @(negedge clk);
    upValid = 1; upThread = thr; upKernel = krn; upPc = pc; upTarget = tgt;
    @(negedge clk);
    upValid = 0;
  endtask

  task automatic writeCfg(input logic [2:0] v);
    @(negedge clk);
    cfgWe = 1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    @(negedge clk);
    check({61'd0, cfgPolicy}, {61'd0, 3'b011}, "R1 policy");
    check({61'd0, cfgPolicyL}, {61'd0, 3'b011}, "R1 locked policy");
    look(0, 0, PA, 0, 0, "R1 empty lookup");
    look(1, 1, PC, 0, 0, "R1 empty lookup");

    for (int i = 0; i < 11; i++) begin
      if (VEC[i].isUpd) train(VEC[i].thr, VEC[i].krn, VEC[i].pc, VEC[i].tgt);
      else begin
        @(negedge clk);
        look(VEC[i].thr, VEC[i].krn, VEC[i].pc, VEC[i].hit, VEC[i].tgt,
             $sformatf("R%0d row %0d", VEC[i].req, i));
      end
    end

    // R8: colliding update and lookup see old contents
    @(negedge clk);
    upValid = 1; upThread = 0; upKernel = 0; upPc = PB; upTarget = 32'h1234_5678;
    look(0, 0, PB, 1, T3, "R8 old contents");
    @(negedge clk);
    upValid = 0;
    look(0, 0, PB, 1, 32'h1234_5678, "R8 new contents next cycle");

    // R6: flush, same-cycle lookup misses, same-cycle update dropped
    @(negedge clk);
    flushReq = 1; upValid = 1; upPc = PA; upTarget = T1;
    look(0, 0, PB, 0, 0, "R6 same-cycle miss");
    @(negedge clk);
    flushReq = 0; upValid = 0;
    look(0, 0, PB, 0, 0, "R6 flushed");
    look(0, 0, PA, 0, 0, "R6 update dropped");
    look(1, 1, PC, 0, 0, "R6 other entry flushed");

    // R4/R5 disabled: sharing across mode and thread
    writeCfg(3'b000);
    check({61'd0, cfgPolicy}, {61'd0, 3'b000}, "R9 policy write");
    check({61'd0, cfgPolicyL}, {61'd0, 3'b001}, "R9 forced bit holds");
    train(0, 0, PA, T1);
    @(negedge clk);
    look(1, 1, PA, 1, T1, "R4 R5 checks disabled");

    // R7: event ignored while auto flush off
    @(negedge clk);
    ctxEvt = 1;
    @(negedge clk);
    ctxEvt = 0;
    look(1, 1, PA, 1, T1, "R7 event ignored");

    // R7: event flushes while enabled
    writeCfg(3'b100);
    @(negedge clk);
    ctxEvt = 1;
    look(0, 0, PA, 0, 0, "R7 same-cycle miss");
    @(negedge clk);
    ctxEvt = 0;
    look(0, 0, PA, 0, 0, "R7 flushed by event");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule